// File: doc/BRIEF.md
# Flash Write Status Reporter

This block builds the status byte that a host reads back from a flash-style memory while an embedded program or erase runs, or while an erase is suspended. A command controller supplies the operation state (program busy, erase busy, erase suspended), the bit 7 value being programmed, and a mask of sectors chosen for erase. The host side supplies a read strobe and the sector index decoded from the read address. The block drives a status-select output that tells the read path to return the status byte instead of array data.

Two toggle bits are kept apart. Bit 6 follows the embedded operation as a whole and freezes while an erase is suspended. Bit 2 flips only when a read lands in a sector chosen for erase, so a host can tell an erasing or erase-suspended sector from one that is not part of the erase. Bit 7 is a polling bit: it reads 0 during an erase and the complement of the programmed bit 7 during a program. When the operation ends, status select drops and the array data (all ones after an erase) comes back.

Top module: `flash_status_rpt`

## Requirements
- R1: With program busy, erase busy and erase suspended all low, status_sel is 0, status_byte is 8'h00, and both toggle bits are cleared to 0 within one clock.
- R2: Bit 6 inverts once per rising edge of rd_strobe whenever a program runs (normal or suspended) or an erase runs unsuspended; the new value shows one clock after the edge is sampled.
- R3: Bit 2 inverts once per rising edge of rd_strobe when the read sector is set in erase_sel and the block is erasing, erase-suspended, or programming inside an erase suspend; otherwise it holds.
- R4: While an erase is suspended and no program runs, bit 6 holds its value across reads.
- R5: During an unsuspended erase with no program, status_sel is 1, bit 7 is 0 and bit 3 is 1.
- R6: During a program, normal or inside an erase suspend, status_sel is 1, bit 7 equals the inverse of prog_d7 and bit 3 is 0.
- R7: During an erase suspend with no program, status_sel is 1 only when the read sector is set in erase_sel, and then bit 7 is 1; other sectors return array data (status_sel 0).
- R8: A sector index at or above NUM_SECT never counts as selected for erase.
- R9: Bits 5, 4, 1 and 0 are always 0, and status_byte is 8'h00 whenever status_sel is 0.
- R10: Asserting rst_n low clears both toggle bits at once; release takes effect after the synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | Host read strobe; each rising edge is one status read |
| rd_sector | input | SECT_W | Sector index decoded from the read address |
| prog_busy | input | 1 | Embedded program running |
| erase_busy | input | 1 | Embedded erase in progress (stays high while suspended) |
| erase_susp | input | 1 | Erase suspended |
| erase_sel | input | NUM_SECT | One bit per sector chosen for erase |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| status_sel | output | 1 | Return status_byte instead of array data |
| status_byte | output | 8 | Status byte |

## Verification
On every cycle the assertions check the polling bit and bit 3 against the operation state, the quiet outputs when idle, the zero bits, the one-flip-per-read rule for bit 6 and its freeze in suspend. What only the bench's scenarios show is the sequence of values across whole read series: bit 2 following the sector mask through erase, suspend and suspended program, out-of-range sectors, the hand-over between modes with toggle history kept, and the clearing done by a reset in the middle of an erase.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned POS_POLL = 7;
  localparam int unsigned POS_TGLA = 6;
  localparam int unsigned POS_ERAS = 3;
  localparam int unsigned POS_TGLB = 2;

  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_SUSP      = 3'd3,
    MODE_SUSP_PROG = 3'd4
  } fsr_mode_t;

  function automatic fsr_mode_t fsr_decode_mode(input logic p_busy,
                                                input logic e_busy,
                                                input logic e_susp);
    fsr_mode_t m;
    if (e_susp && p_busy)      m = MODE_SUSP_PROG;
    else if (e_susp)           m = MODE_SUSP;
    else if (p_busy)           m = MODE_PROG;
    else if (e_busy)           m = MODE_ERASE;
    else                       m = MODE_IDLE;
    return m;
  endfunction

endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fsr_edge.sv
module fsr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);

  logic sig_q;
  logic sig_d;

  always_comb begin
    sig_d = sig_in;
    rise  = sig_in & ~sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_d;
  end

endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic q
);

  logic q_d;
  logic q_en;

  always_comb begin
    q_en = clr | flip;
    if (clr) q_d = 1'b0;
    else     q_d = ~q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/fsr_sector_hit.sv
module fsr_sector_hit #(
  parameter int unsigned NUM_SECT = 19,
  localparam int unsigned SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic [SECT_W-1:0]   sector,
  input  logic [NUM_SECT-1:0] sel_mask,
  output logic                hit
);

  logic [NUM_SECT-1:0] match;

  for (genvar gi = 0; gi < NUM_SECT; gi++) begin : g_match
    assign match[gi] = sel_mask[gi] && (sector == SECT_W'(gi));
  end

  assign hit = |match;

endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
  import fsr_pkg::*;
#(
  parameter int unsigned NUM_SECT    = 19,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SECT_W     = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_strobe,
  input  logic [SECT_W-1:0]   rd_sector,
  input  logic                prog_busy,
  input  logic                erase_busy,
  input  logic                erase_susp,
  input  logic [NUM_SECT-1:0] erase_sel,
  input  logic                prog_d7,
  output logic                status_sel,
  output logic [BYTE_W-1:0]   status_byte
);

  logic      rst_sync_n;
  logic      rd_rise;
  logic      sect_hit;
  fsr_mode_t mode;
  logic      op_idle;
  logic      tgla_run;
  logic      tglb_run;
  logic      tgla_q;
  logic      tglb_q;
  logic      tgla_flip;
  logic      tglb_flip;

  fsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsr_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_in (rd_strobe),
    .rise   (rd_rise)
  );

  fsr_sector_hit #(.NUM_SECT(NUM_SECT)) u_hit (
    .sector   (rd_sector),
    .sel_mask (erase_sel),
    .hit      (sect_hit)
  );

  always_comb begin
    mode     = fsr_decode_mode(prog_busy, erase_busy, erase_susp);
    op_idle  = (mode == MODE_IDLE);
    tgla_run = (mode == MODE_PROG) || (mode == MODE_ERASE) ||
               (mode == MODE_SUSP_PROG);
    tglb_run = (mode == MODE_ERASE) || (mode == MODE_SUSP) ||
               (mode == MODE_SUSP_PROG);
    tgla_flip = rd_rise && tgla_run;
    tglb_flip = rd_rise && tglb_run && sect_hit;
  end

  fsr_toggle u_tgla (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (op_idle),
    .flip  (tgla_flip),
    .q     (tgla_q)
  );

  fsr_toggle u_tglb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (op_idle),
    .flip  (tglb_flip),
    .q     (tglb_q)
  );

  always_comb begin
    status_sel  = 1'b0;
    status_byte = '0;
    case (mode)
      MODE_PROG, MODE_SUSP_PROG: begin
        status_sel            = 1'b1;
        status_byte[POS_POLL] = ~prog_d7;
      end
      MODE_ERASE: begin
        status_sel            = 1'b1;
        status_byte[POS_POLL] = 1'b0;
        status_byte[POS_ERAS] = 1'b1;
      end
      MODE_SUSP: begin
        status_sel            = sect_hit;
        status_byte[POS_POLL] = 1'b1;
      end
      default: begin
        status_sel = 1'b0;
      end
    endcase
    if (status_sel) begin
      status_byte[POS_TGLA] = tgla_q;
      status_byte[POS_TGLB] = tglb_q;
    end else begin
      status_byte = '0;
    end
  end

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              rd_strobe,
  input logic              prog_busy,
  input logic              erase_busy,
  input logic              erase_susp,
  input logic              prog_d7,
  input logic              status_sel,
  input logic [BYTE_W-1:0] status_byte
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    (!prog_busy && !erase_busy && !erase_susp) |-> (!status_sel && status_byte == '0)); // R1

  AST_TGLA_FLIP: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_strobe && !$past(rd_strobe) && (prog_busy || (erase_busy && !erase_susp)))
      |=> (!(prog_busy || (erase_busy && !erase_susp)) ||
           status_byte[6] != $past(status_byte[6]))); // R2

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (erase_susp && !prog_busy && status_sel)
      |=> (!(erase_susp && !prog_busy && status_sel) || $stable(status_byte[6]))); // R4

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_ok)
    (erase_busy && !erase_susp && !prog_busy)
      |-> (status_sel && !status_byte[7] && status_byte[3])); // R5

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_ok)
    prog_busy |-> (status_sel && (status_byte[7] == !prog_d7) && !status_byte[3])); // R6

  AST_SUSP_POLL: assert property (@(posedge clk) disable iff (!rst_ok)
    (erase_susp && !prog_busy && status_sel) |-> status_byte[7]); // R7

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_ok)
    (status_byte[5:4] == 2'b00 && status_byte[1:0] == 2'b00 &&
     (status_sel || status_byte == '0))); // R9

endmodule

bind flash_status_rpt fsr_checker #(.BYTE_W(fsr_pkg::BYTE_W)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .rd_strobe   (rd_strobe),
  .prog_busy   (prog_busy),
  .erase_busy  (erase_busy),
  .erase_susp  (erase_susp),
  .prog_d7     (prog_d7),
  .status_sel  (status_sel),
  .status_byte (status_byte)
);

// File: tb/flash_status_rpt_tb.sv
module flash_status_rpt_tb;

  localparam int unsigned NS = 19;
  localparam int unsigned SW = $clog2(NS);

  typedef struct {
    string      tag;
    logic       sel;
    logic [7:0] val;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          rd_strobe;
  logic [SW-1:0] rd_sector;
  logic          prog_busy, erase_busy, erase_susp, prog_d7;
  logic [NS-1:0] erase_sel;
  logic          status_sel;
  logic [7:0]    status_byte;

  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;
  exp_t sb_q[$];

  // bench model state
  bit m_p, m_e, m_s, m_d7, m_t6, m_t2;

  flash_status_rpt #(.NUM_SECT(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .erase_susp(erase_susp),
    .erase_sel(erase_sel), .prog_d7(prog_d7),
    .status_sel(status_sel), .status_byte(status_byte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit is_hit(input int sec);
    return (sec < NS) && erase_sel[sec];
  endfunction

  function automatic exp_t model_out(input int sec, input string tag);
    exp_t e;
    bit idle;
    idle  = !m_p && !m_e && !m_s;
    e.tag = tag;
    if (idle)           e.sel = 1'b0;
    else if (m_s && !m_p) e.sel = is_hit(sec);
    else                e.sel = 1'b1;
    e.val = 8'h00;
    if (e.sel) begin
      e.val[7] = m_p ? !m_d7 : m_s;
      e.val[6] = m_t6;
      e.val[3] = m_e && !m_s && !m_p;
      e.val[2] = m_t2;
    end
    return e;
  endfunction

  task automatic set_mode(input bit p, input bit e, input bit s, input bit d7);
    @(negedge clk);
    prog_busy = p; erase_busy = e; erase_susp = s; prog_d7 = d7;
    m_p = p; m_e = e; m_s = s; m_d7 = d7;
    repeat (2) @(negedge clk);
    if (!p && !e && !s) begin m_t6 = 0; m_t2 = 0; end
  endtask

  task automatic do_read(input int sec, input string tag);
    @(negedge clk);
    rd_sector = SW'(sec);
    rd_strobe = 1'b1;
    if (m_p || (m_e && !m_s)) m_t6 = !m_t6;
    if ((m_s || (m_e && !m_p)) && is_hit(sec)) m_t2 = !m_t2;
    @(posedge clk);
    sb_q.push_back(model_out(sec, tag));
    @(negedge clk);
    rd_strobe = 1'b0;
    wait (sb_q.size() == 0);
  endtask

  task automatic expect_now(input string tag);
    @(posedge clk);
    sb_q.push_back(model_out(int'(rd_sector), tag));
    @(negedge clk);
    wait (sb_q.size() == 0);
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (status_sel !== e.sel || status_byte !== e.val) begin
          errors++;
          $display("FAIL %s: sel=%b byte=%h expected sel=%b byte=%h",
                   e.tag, status_sel, status_byte, e.sel, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_strobe = 1'b0; rd_sector = '0;
    prog_busy = 0; erase_busy = 0; erase_susp = 0; prog_d7 = 0;
    erase_sel = '0;
    m_p = 0; m_e = 0; m_s = 0; m_d7 = 0; m_t6 = 0; m_t2 = 0;
    repeat (3) @(negedge clk);
    expect_now("R10 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_read(0, "R1 idle read returns array data");

    // normal program
    set_mode(1, 0, 0, 1);
    do_read(2, "R2 R6 program read 1");
    do_read(2, "R2 R6 program read 2");
    set_mode(1, 0, 0, 0);
    do_read(7, "R2 R6 program inverted d7");
    set_mode(0, 0, 0, 0);
    do_read(2, "R1 idle after program, toggles cleared");
    expect_now("R9 idle byte zero");

    // erase with sectors 3 and 5 selected
    erase_sel = '0; erase_sel[3] = 1'b1; erase_sel[5] = 1'b1;
    set_mode(0, 1, 0, 0);
    do_read(3, "R3 R5 erase read selected");
    do_read(2, "R3 R5 erase read unselected, bit2 holds");
    do_read(3, "R3 R2 erase read selected again");
    do_read(25, "R8 out-of-range sector in erase");

    // suspend
    set_mode(0, 1, 1, 0);
    do_read(4, "R7 suspend unselected returns array");
    do_read(5, "R4 R7 R3 suspend selected");
    do_read(5, "R4 R3 suspend selected again");
    do_read(25, "R8 out-of-range sector in suspend");

    // program inside suspend
    set_mode(1, 1, 1, 0);
    do_read(4, "R6 R2 suspended program read");
    do_read(3, "R6 R3 suspended program selected sector");
    set_mode(1, 1, 1, 1);
    do_read(4, "R6 suspended program d7 set");
    set_mode(0, 1, 1, 0);
    do_read(3, "R4 back in suspend");

    // resume, then reset mid-erase
    set_mode(0, 1, 0, 0);
    do_read(5, "R2 R3 resumed erase");
    @(negedge clk);
    rst_n = 1'b0;
    m_t6 = 0; m_t2 = 0;
    @(negedge clk);
    expect_now("R10 toggles cleared by reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(3, "R10 R2 first read after reset");
    set_mode(0, 0, 0, 0);
    do_read(3, "R1 erase done, array data");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule